// File: doc/BRIEF.md
# Parallel NOR Flash Bus-Mode Controller

This block sits behind the pins of a parallel NOR flash and decides, clock by clock, how the device responds to the bus. It samples the active-low chip enable, output enable, write enable and hardware reset pins on a system clock. It frames write cycles and keeps track of the device's operating mode. That mode can be read array, a timed program, a timed erase, the stop of an erase, a suspended erase, a program inside a suspended erase, identification (autoselect or CFI query), a failed operation, or recovery from a hardware reset.

For every read it picks one source. The source is the storage array, the status or identification register, or nothing (tri-state). It also drives a ready/busy flag. The storage array, the decoding of command codes and all electrical behaviour sit outside the block. A decoder delivers each command as a small abstract type on the `cmd` input, which the block samples together with the write data.

Each pin is registered once before use. Every output therefore reflects the pin levels seen at the previous rising clock edge. Embedded program, erase, suspend and reset-recovery times are counts of clock cycles, set by parameters.

Top module: `nor_mode_ctrl`

## Requirements
- R1: After the system reset is released, the block is in read-array mode with `rdy`=1, `q5_fail`=0, `dout_oe`=0 and no write pulse.
- R2: `dout_oe` is 1 exactly when the sampled CE# and OE# are both low. `arr_rd` and `stat_sel` are never both 1, and each is 1 only while `dout_oe` is 1. In read-array mode every read sets `arr_rd`.
- R3: A write cycle lasts while the sampled CE# and WE# are both low and OE# is high. The address is taken from the first such cycle. The data, `cmd` and `inject_fail` are taken from the last such cycle. `wcap_valid` pulses for one cycle, in the cycle after the enables end the write. A cycle with OE# low is never a write.
- R4: Command encoding: 1 program, 2 erase, 3 suspend, 4 resume, 5 reset, 6 identify, 0 no-op. A program accepted in read-array mode holds `rdy`=0 for PROG_CYC cycles after the cycle of `wcap_valid`, with reads returning status. The block then returns to read array without any further command.
- R5: An erase accepted in read-array mode records the sector as `addr >> SECT_BITS` from the write address. It stays busy for ERASE_CYC cycles with reads returning status, then returns to read array.
- R6: A suspend accepted during an erase makes the block ready again exactly TREADY_CYC cycles after acceptance.
- R7: While the erase is suspended, a read whose sector equals the recorded sector sets `stat_sel`, and any other read sets `arr_rd`.
- R8: A program accepted during suspension runs for PROG_CYC cycles. Afterwards the block is back in suspension and applies the R7 sector rule unchanged.
- R9: A resume accepted during suspension makes the block busy again and continues the erase for its remaining cycles. After that the block is in read array, and reads in the erased sector set `arr_rd`.
- R10: If `inject_fail` is 1 with a program or erase command, the block reaches the failure state when that operation ends: `q5_fail`=1, `rdy`=0, every read returns status. It stays there until a reset command.
- R11: An identify command in read-array mode gives `rdy`=1 with every read selecting `stat_sel`. Only a reset command returns the block to read array.
- R12: The hardware reset pin is honoured after TRP_CYC consecutive low samples, and a shorter pulse has no effect. From an idle mode the block enters read array at once. From an embedded operation it stays busy for TREADY_CYC cycles and then enters read array, with `q5_fail`=0.
- R13: A command that is not listed for the current mode has no effect on mode, timing or read source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | System reset, active low, asynchronous |
| ce_n | input | 1 | Chip enable pin, active low |
| oe_n | input | 1 | Output enable pin, active low |
| we_n | input | 1 | Write enable pin, active low |
| hwrst_n | input | 1 | Device hardware reset pin, active low |
| addr | input | AW | Bus address |
| wdata | input | DW | Bus write data |
| cmd | input | 3 | Decoded command type of the current write |
| inject_fail | input | 1 | Test input: the accompanying program or erase ends in failure |
| rdy | output | 1 | Ready (1) or busy (0) |
| dout_oe | output | 1 | Data output driver enable |
| arr_rd | output | 1 | Read served from the array |
| stat_sel | output | 1 | Read served from the status or identification register |
| q5_fail | output | 1 | Operation failure status bit |
| wcap_valid | output | 1 | One-cycle pulse: a write cycle has completed |
| wcap_addr | output | AW | Address captured for the completed write |
| wcap_data | output | DW | Data captured for the completed write |

## Verification
The bench staggers the two write enables and changes address and data partway through a write. A capture on the wrong edge would report the second address or the first data. It measures the busy windows of program, erase and suspend to the cycle, because an off-by-one timer load moves the moment `rdy` rises. It sweeps all addresses in read array and in suspension, where a wrong sector slice or a swapped comparison would show up as status returned for the wrong sectors. Illegal commands, reset pulses one sample short, and program and erase writes in failure and identification modes check that nothing leaves a sticky mode early, and that a short pulse is not taken as a reset.

// File: rtl/nor_mode_pkg.sv
package nor_mode_pkg;

   typedef enum logic [2:0] {
      CMD_NONE    = 3'd0,
      CMD_PROG    = 3'd1,
      CMD_ERASE   = 3'd2,
      CMD_SUSPEND = 3'd3,
      CMD_RESUME  = 3'd4,
      CMD_RESET   = 3'd5,
      CMD_IDENT   = 3'd6
   } cmd_e;

   typedef enum logic [3:0] {
      M_READ,
      M_PROG,
      M_ERASE,
      M_SUSPENDING,
      M_SUSP,
      M_SUSP_PROG,
      M_IDENT,
      M_FAIL,
      M_RSTREC
   } mode_e;

   // modes whose hardware reset needs a recovery interval
   function automatic logic mode_embedded(mode_e m);
      return m inside {M_PROG, M_ERASE, M_SUSPENDING, M_SUSP_PROG, M_RSTREC};
   endfunction

   function automatic logic mode_ready(mode_e m);
      return m inside {M_READ, M_SUSP, M_IDENT};
   endfunction

endpackage

// File: rtl/nor_wr_capture.sv
// Frames one bus write: address on entry, data and command on the last active cycle.
module nor_wr_capture #(
   parameter int AW  = 20,
   parameter int DW  = 16,
   parameter int CMW = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           ce_q,
   input  logic           we_q,
   input  logic           oe_q,
   input  logic [AW-1:0]  addr_i,
   input  logic [DW-1:0]  data_i,
   input  logic [CMW-1:0] cmd_i,
   output logic           done_o,
   output logic [AW-1:0]  addr_o,
   output logic [DW-1:0]  data_o,
   output logic [CMW-1:0] cmd_o
);

   logic act, act_d;

   assign act    = !ce_q && !we_q && oe_q;
   assign done_o = act_d && !act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_d  <= 1'b0;
         addr_o <= '0;
         data_o <= '0;
         cmd_o  <= '0;
      end else begin
         act_d <= act;
         if (act && !act_d) addr_o <= addr_i;
         if (act) begin
            data_o <= data_i;
            cmd_o  <= cmd_i;
         end
      end
   end

endmodule

// File: rtl/nor_op_timer.sv
// Down-counter for embedded operation lengths; last_o marks the final busy cycle.
module nor_op_timer #(
   parameter int CW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [CW-1:0] val_i,
   output logic [CW-1:0] cnt_o,
   output logic          last_o
);

   assign last_o = (cnt_o == CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_o <= '0;
      else if (load_i)         cnt_o <= val_i;
      else if (cnt_o != '0)    cnt_o <= cnt_o - CW'(1);
   end

endmodule

// File: rtl/nor_sector_match.sv
// Compares the sector field of an address with the recorded erase sector.
module nor_sector_match #(
   parameter int AW = 20,
   parameter int SB = 16,
   localparam int SW = AW - SB
) (
   input  logic [AW-1:0] addr_i,
   input  logic [SW-1:0] sect_i,
   output logic          hit_o
);

   generate
      if (SB == 0) begin : g_word_sectors
         assign hit_o = (addr_i == sect_i);
      end else begin : g_block_sectors
         logic unused_offset;
         assign unused_offset = ^addr_i[SB-1:0];
         assign hit_o = (addr_i[AW-1:SB] == sect_i);
      end
   endgenerate

endmodule

// File: rtl/nor_mode_ctrl.sv
module nor_mode_ctrl
   import nor_mode_pkg::*;
#(
   parameter int AW         = 20,
   parameter int DW         = 16,
   parameter int SECT_BITS  = 16,
   parameter int PROG_CYC   = 40,
   parameter int ERASE_CYC  = 400,
   parameter int TREADY_CYC = 20,
   parameter int TRP_CYC    = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ce_n,
   input  logic          oe_n,
   input  logic          we_n,
   input  logic          hwrst_n,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   input  logic [2:0]    cmd,
   input  logic          inject_fail,
   output logic          rdy,
   output logic          dout_oe,
   output logic          arr_rd,
   output logic          stat_sel,
   output logic          q5_fail,
   output logic          wcap_valid,
   output logic [AW-1:0] wcap_addr,
   output logic [DW-1:0] wcap_data
);

   localparam int SW   = AW - SECT_BITS;
   localparam int M1   = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
   localparam int MAXC = (M1 > TREADY_CYC) ? M1 : TREADY_CYC;
   localparam int CW   = $clog2(MAXC + 1);
   localparam int RW   = $clog2(TRP_CYC + 1);

   generate
      if (SECT_BITS < 0 || SECT_BITS >= AW) begin : g_bad_sect
         $error("SECT_BITS must lie in [0, AW-1]");
      end
      if (PROG_CYC < 2 || ERASE_CYC < 2 || TREADY_CYC < 2) begin : g_bad_cyc
         $error("operation lengths must be at least 2 cycles");
      end
      if (TRP_CYC < 1) begin : g_bad_trp
         $error("TRP_CYC must be at least 1");
      end
   endgenerate

   // ---- pin sampling ----
   logic          ce_q, oe_q, we_q, rp_q;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] data_q;
   logic [3:0]    cmd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ce_q   <= 1'b1;
         oe_q   <= 1'b1;
         we_q   <= 1'b1;
         rp_q   <= 1'b1;
         addr_q <= '0;
         data_q <= '0;
         cmd_q  <= '0;
      end else begin
         ce_q   <= ce_n;
         oe_q   <= oe_n;
         we_q   <= we_n;
         rp_q   <= hwrst_n;
         addr_q <= addr;
         data_q <= wdata;
         cmd_q  <= {inject_fail, cmd};
      end
   end

   // ---- write framing ----
   logic [3:0] cap_cmd;
   cmd_e       wc;
   logic       inj;

   nor_wr_capture #(.AW(AW), .DW(DW), .CMW(4)) u_wcap (
      .clk    (clk),
      .rst_n  (rst_n),
      .ce_q   (ce_q),
      .we_q   (we_q),
      .oe_q   (oe_q),
      .addr_i (addr_q),
      .data_i (data_q),
      .cmd_i  (cmd_q),
      .done_o (wcap_valid),
      .addr_o (wcap_addr),
      .data_o (wcap_data),
      .cmd_o  (cap_cmd)
   );

   assign wc  = cmd_e'(cap_cmd[2:0]);
   assign inj = cap_cmd[3];

   // ---- hardware reset pulse qualification ----
   logic [RW-1:0] rcnt;
   logic          rp_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      rcnt <= '0;
      else if (rp_q)                   rcnt <= '0;
      else if (rcnt != RW'(TRP_CYC))   rcnt <= rcnt + RW'(1);
   end

   assign rp_hit = !rp_q && (rcnt == RW'(TRP_CYC - 1));

   // ---- operation timer and sector compare ----
   logic          ld, tlast;
   logic [CW-1:0] ldv, tcnt;
   logic [SW-1:0] sect_q, sect_n;
   logic          sect_hit;

   nor_op_timer #(.CW(CW)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (ld),
      .val_i  (ldv),
      .cnt_o  (tcnt),
      .last_o (tlast)
   );

   nor_sector_match #(.AW(AW), .SB(SECT_BITS)) u_smatch (
      .addr_i (addr_q),
      .sect_i (sect_q),
      .hit_o  (sect_hit)
   );

   // ---- mode sequencing ----
   mode_e         mode, mode_n;
   logic [CW-1:0] left_q, left_n;
   logic          arm_p, arm_p_n, arm_e, arm_e_n;

   always_comb begin
      mode_n  = mode;
      sect_n  = sect_q;
      left_n  = left_q;
      arm_p_n = arm_p;
      arm_e_n = arm_e;
      ld      = 1'b0;
      ldv     = '0;
      if (rp_hit) begin
         arm_p_n = 1'b0;
         arm_e_n = 1'b0;
         if (mode_embedded(mode)) begin
            mode_n = M_RSTREC;
            ld     = 1'b1;
            ldv    = CW'(TREADY_CYC);
         end else begin
            mode_n = M_READ;
         end
      end else begin
         unique case (mode)
            M_READ: begin
               if (wcap_valid && wc == CMD_PROG) begin
                  mode_n  = M_PROG;
                  ld      = 1'b1;
                  ldv     = CW'(PROG_CYC);
                  arm_p_n = inj;
               end else if (wcap_valid && wc == CMD_ERASE) begin
                  mode_n  = M_ERASE;
                  ld      = 1'b1;
                  ldv     = CW'(ERASE_CYC);
                  arm_e_n = inj;
                  sect_n  = wcap_addr[AW-1:SECT_BITS];
               end else if (wcap_valid && wc == CMD_IDENT) begin
                  mode_n = M_IDENT;
               end
            end
            M_PROG:       if (tlast) mode_n = arm_p ? M_FAIL : M_READ;
            M_ERASE: begin
               if (tlast) begin
                  mode_n = arm_e ? M_FAIL : M_READ;
               end else if (wcap_valid && wc == CMD_SUSPEND) begin
                  mode_n = M_SUSPENDING;
                  left_n = tcnt;
                  ld     = 1'b1;
                  ldv    = CW'(TREADY_CYC);
               end
            end
            M_SUSPENDING: if (tlast) mode_n = M_SUSP;
            M_SUSP: begin
               if (wcap_valid && wc == CMD_PROG) begin
                  mode_n  = M_SUSP_PROG;
                  ld      = 1'b1;
                  ldv     = CW'(PROG_CYC);
                  arm_p_n = inj;
               end else if (wcap_valid && wc == CMD_RESUME) begin
                  mode_n = M_ERASE;
                  ld     = 1'b1;
                  ldv    = left_q;
               end
            end
            M_SUSP_PROG:  if (tlast) mode_n = arm_p ? M_FAIL : M_SUSP;
            M_IDENT, M_FAIL: if (wcap_valid && wc == CMD_RESET) mode_n = M_READ;
            M_RSTREC:     if (tlast) mode_n = M_READ;
            default:      mode_n = M_READ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode   <= M_READ;
         sect_q <= '0;
         left_q <= '0;
         arm_p  <= 1'b0;
         arm_e  <= 1'b0;
      end else begin
         mode   <= mode_n;
         sect_q <= sect_n;
         left_q <= left_n;
         arm_p  <= arm_p_n;
         arm_e  <= arm_e_n;
      end
   end

   // ---- read source selection ----
   logic array_ok;

   always_comb begin
      unique case (mode)
         M_READ:  array_ok = 1'b1;
         M_SUSP:  array_ok = !sect_hit;
         default: array_ok = 1'b0;
      endcase
   end

   assign dout_oe  = !ce_q && !oe_q;
   assign arr_rd   = dout_oe && array_ok;
   assign stat_sel = dout_oe && !array_ok;
   assign rdy      = mode_ready(mode);
   assign q5_fail  = (mode == M_FAIL);

endmodule

// File: rtl/nor_mode_ctrl_chk.sv
module nor_mode_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic ce_n,
   input logic oe_n,
   input logic rdy,
   input logic dout_oe,
   input logic arr_rd,
   input logic stat_sel,
   input logic q5_fail,
   input logic wcap_valid
);

   // R2: either enable high at an edge leaves the driver off after it
   a_r2_tristate: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_n || oe_n) |=> !dout_oe);

   // R2: both low at an edge turns the driver on after it
   a_r2_drive: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && !oe_n) |=> dout_oe);

   // R2: one read source at a time
   a_r2_one_source: assert property (@(posedge clk) disable iff (!rst_n)
      !(arr_rd && stat_sel));

   // R2: a source is only chosen while the driver is on
   a_r2_source_needs_oe: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_rd || stat_sel) |-> dout_oe);

   // R10: a failed device is busy and never serves array data
   a_r10_fail_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      q5_fail |-> (!rdy && !arr_rd));

   // R3: a write completion is a single-cycle pulse
   a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      wcap_valid |=> !wcap_valid);

endmodule

bind nor_mode_ctrl nor_mode_ctrl_chk i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ce_n       (ce_n),
   .oe_n       (oe_n),
   .rdy        (rdy),
   .dout_oe    (dout_oe),
   .arr_rd     (arr_rd),
   .stat_sel   (stat_sel),
   .q5_fail    (q5_fail),
   .wcap_valid (wcap_valid)
);

// File: tb/test_nor_mode_ctrl.sv
`timescale 1ns/1ps
module test_nor_mode_ctrl;

   localparam int AW = 8, DW = 8, SB = 4;
   localparam int PC = 20, EC = 40, TR = 3, TP = 4;
   localparam logic [2:0] C_NONE = 3'd0, C_PROG = 3'd1, C_ERASE = 3'd2, C_SUSP = 3'd3,
                          C_RES = 3'd4, C_RST = 3'd5, C_ID = 3'd6;

   logic clk = 1'b0, rst_n = 1'b0;
   logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, hwrst_n = 1'b1, inject_fail = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [2:0]    cmd = '0;
   logic rdy, dout_oe, arr_rd, stat_sel, q5_fail, wcap_valid;
   logic [AW-1:0] wcap_addr;
   logic [DW-1:0] wcap_data;

   int n_chk = 0, n_fail = 0;

   always #4 clk = ~clk;

   nor_mode_ctrl #(.AW(AW), .DW(DW), .SECT_BITS(SB), .PROG_CYC(PC), .ERASE_CYC(EC),
                   .TREADY_CYC(TR), .TRP_CYC(TP)) i_nor_mode_ctrl (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .hwrst_n(hwrst_n),
      .addr(addr), .wdata(wdata), .cmd(cmd), .inject_fail(inject_fail),
      .rdy(rdy), .dout_oe(dout_oe), .arr_rd(arr_rd), .stat_sel(stat_sel), .q5_fail(q5_fail),
      .wcap_valid(wcap_valid), .wcap_addr(wcap_addr), .wcap_data(wcap_data));

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic report();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   endtask

   // one-cycle write; called and returning at a falling edge
   task automatic wr(input logic [7:0] a, input logic [2:0] c, input logic inj);
      ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = a; cmd = c; wdata = a ^ 8'h5A;
      inject_fail = inj;
      @(negedge clk);
      ce_n = 1'b1; we_n = 1'b1; inject_fail = 1'b0; cmd = C_NONE;
   endtask

   // after wr: checks the pulse, the exact busy length and the read source at the end
   task automatic busy_window(input int n, input logic [7:0] ra, input logic rdy_end,
                              input logic arr_end, input string tag);
      @(negedge clk);
      chk(wcap_valid, "R3 pulse", int'(wcap_valid), 1);
      @(negedge clk);
      chk(!rdy, tag, int'(rdy), 0);
      ce_n = 1'b0; oe_n = 1'b0; addr = ra;
      repeat (n - 1) @(negedge clk);
      chk(!rdy && stat_sel, tag, int'({rdy, stat_sel}), 1);
      @(negedge clk);
      chk(rdy == rdy_end && arr_rd == arr_end && stat_sel == !arr_end, tag,
          int'({rdy, arr_rd, stat_sel}), int'({rdy_end, arr_end, !arr_end}));
      ce_n = 1'b1; oe_n = 1'b1;
   endtask

   task automatic read_src(input logic [7:0] ra, input logic arr_exp, input string tag);
      ce_n = 1'b0; oe_n = 1'b0; addr = ra;
      @(negedge clk);
      chk(arr_rd == arr_exp && stat_sel == !arr_exp && dout_oe, tag,
          int'({arr_rd, stat_sel}), int'({arr_exp, !arr_exp}));
      ce_n = 1'b1; oe_n = 1'b1;
   endtask

   task automatic sweep(input int sect, input logic susp, input string tag);
      for (int a = 0; a < 256; a++) begin
         logic st;
         ce_n = 1'b0; oe_n = 1'b0; addr = a[7:0];
         @(negedge clk);
         st = susp && ((a >> SB) == sect);
         chk(stat_sel == st && arr_rd == !st, tag, int'({arr_rd, stat_sel}), int'({!st, st}));
      end
      ce_n = 1'b1; oe_n = 1'b1;
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired act=0 exp=1");
      report();
   end

   initial begin
      int n;
      logic seen;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk(rdy && !q5_fail && !dout_oe && !wcap_valid, "R1 reset state",
          int'({rdy, q5_fail, dout_oe, wcap_valid}), 8);

      // R2: all enable combinations, write enable high
      for (int k = 0; k < 4; k++) begin
         ce_n = k[1]; oe_n = k[0];
         @(negedge clk);
         chk(dout_oe == (k == 0) && arr_rd == (k == 0) && !stat_sel, "R2 enable gate",
             int'({dout_oe, arr_rd, stat_sel}), (k == 0) ? 6 : 0);
      end
      ce_n = 1'b1; oe_n = 1'b1;
      sweep(0, 1'b0, "R2 read array sweep");

      // R3: staggered enables, address from first, data from last active cycle
      ce_n = 1'b0; addr = 8'h11; wdata = 8'h01;
      @(negedge clk); we_n = 1'b0;
      @(negedge clk); addr = 8'h22; wdata = 8'h5A;
      @(negedge clk); ce_n = 1'b1; wdata = 8'h77;
      @(negedge clk);
      chk(wcap_valid && wcap_addr == 8'h11 && wcap_data == 8'h5A, "R3 capture",
          int'({wcap_addr, wcap_data}), int'({8'h11, 8'h5A}));
      we_n = 1'b1;
      @(negedge clk);
      chk(!wcap_valid, "R3 single pulse", int'(wcap_valid), 0);
      chk(rdy, "R13 no-op command", int'(rdy), 1);
      // R3: OE low never frames a write
      seen = 1'b0;
      ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
      repeat (2) begin @(negedge clk); seen |= wcap_valid; end
      ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
      repeat (3) begin @(negedge clk); seen |= wcap_valid; end
      chk(!seen, "R3 OE low is not a write", int'(seen), 0);

      // R4: program busy window
      wr(8'h30, C_PROG, 1'b0);
      busy_window(PC, 8'h31, 1'b1, 1'b1, "R4 program");
      // R5: erase busy window, reads in the erased sector give status
      wr(8'h35, C_ERASE, 1'b0);
      busy_window(EC, 8'h3F, 1'b1, 1'b1, "R5 erase");

      // R6: suspend an erase of sector A
      wr(8'hA0, C_ERASE, 1'b0);
      settle(2);
      chk(!rdy, "R5 erase busy", int'(rdy), 0);
      wr(8'h00, C_SUSP, 1'b0);
      busy_window(TR, 8'hA5, 1'b1, 1'b0, "R6 suspend latency");
      sweep(10, 1'b1, "R7 suspended sweep");

      // R8: program during suspension
      wr(8'h12, C_PROG, 1'b0);
      busy_window(PC, 8'hA7, 1'b1, 1'b0, "R8 program in suspend");
      sweep(10, 1'b1, "R8 suspended sweep");

      // R9: resume continues the erase
      wr(8'h00, C_RES, 1'b0);
      settle(2);
      chk(!rdy, "R9 resumed busy", int'(rdy), 0);
      n = 0;
      while (!rdy && n < EC + 4) begin @(negedge clk); n++; end
      chk(rdy && n < EC, "R9 resume completes", n, EC);
      read_src(8'hA5, 1'b1, "R9 array after erase");

      // R13: commands illegal in read array
      wr(8'h00, C_SUSP, 1'b0); settle(2);
      chk(rdy, "R13 suspend ignored", int'(rdy), 1);
      wr(8'h00, C_RES, 1'b0); settle(2);
      chk(rdy, "R13 resume ignored", int'(rdy), 1);
      wr(8'h00, C_RST, 1'b0); settle(2);
      chk(rdy, "R13 reset in read array", int'(rdy), 1);
      read_src(8'h44, 1'b1, "R13 still read array");
      // R13: erase during a program is ignored, program ends on time
      wr(8'h00, C_PROG, 1'b0);
      settle(2);
      wr(8'h50, C_ERASE, 1'b0);
      settle(PC + 1 - 3);
      chk(!rdy, "R13 program still busy", int'(rdy), 0);
      @(negedge clk);
      chk(rdy, "R13 program ends on time", int'(rdy), 1);
      settle(3);
      chk(rdy, "R13 erase was ignored", int'(rdy), 1);
      read_src(8'h55, 1'b1, "R13 no erase sector");

      // R10: forced program failure
      wr(8'h20, C_PROG, 1'b1);
      busy_window(PC, 8'h21, 1'b0, 1'b0, "R10 failed program");
      chk(q5_fail, "R10 q5 set", int'(q5_fail), 1);
      settle(10);
      chk(q5_fail && !rdy, "R10 failure sticks", int'({q5_fail, rdy}), 2);
      wr(8'h20, C_PROG, 1'b0); settle(3);
      chk(q5_fail && !rdy, "R10 program ignored in failure", int'({q5_fail, rdy}), 2);
      read_src(8'h20, 1'b0, "R10 status read");
      wr(8'h00, C_RST, 1'b0); settle(2);
      chk(rdy && !q5_fail, "R10 reset command clears", int'({rdy, q5_fail}), 2);
      read_src(8'h20, 1'b1, "R10 array after reset");
      // R10: forced erase failure
      wr(8'h60, C_ERASE, 1'b1);
      busy_window(EC, 8'h61, 1'b0, 1'b0, "R10 failed erase");
      chk(q5_fail, "R10 erase q5", int'(q5_fail), 1);
      wr(8'h00, C_RST, 1'b0); settle(2);
      chk(rdy && !q5_fail, "R10 erase failure cleared", int'({rdy, q5_fail}), 2);

      // R11: identification mode
      wr(8'h00, C_ID, 1'b0); settle(2);
      chk(rdy, "R11 ident ready", int'(rdy), 1);
      read_src(8'h40, 1'b0, "R11 ident read");
      wr(8'h70, C_ERASE, 1'b0); settle(30);
      chk(rdy, "R11 erase ignored", int'(rdy), 1);
      read_src(8'h71, 1'b0, "R11 ident sticks");
      wr(8'h00, C_RST, 1'b0); settle(2);
      read_src(8'h40, 1'b1, "R11 reset leaves ident");

      // R12: hardware reset pin
      wr(8'h00, C_ID, 1'b0); settle(2);
      hwrst_n = 1'b0; settle(TP - 1); hwrst_n = 1'b1; settle(3);
      read_src(8'h40, 1'b0, "R12 short pulse ignored");
      hwrst_n = 1'b0; settle(TP); hwrst_n = 1'b1; settle(2);
      chk(rdy, "R12 idle reset ready", int'(rdy), 1);
      read_src(8'h40, 1'b1, "R12 idle reset to array");
      wr(8'h00, C_PROG, 1'b1); settle(2);
      hwrst_n = 1'b0; settle(TP); hwrst_n = 1'b1;
      chk(!rdy, "R12 busy during recovery", int'(rdy), 0);
      n = 0;
      while (!rdy && n < TR + 6) begin @(negedge clk); n++; end
      chk(rdy && !q5_fail && n >= TR, "R12 recovery length", n, TR + 1);
      read_src(8'h00, 1'b1, "R12 array after recovery");

      report();
   end

endmodule